// File: doc/BRIEF.md
# Button Press-Type Classifier

This block takes one active-low push-button line, already free of contact bounce, and sorts the activity on it into three kinds of event: a single press, a double-click or a long press. A free-running prescaler divides the system clock into a millisecond tick. One duration counter, advanced only on that tick, times how long the line stays low and how long the gap between two presses lasts. A small state machine compares the counter against three thresholds that are set as parameters.

The block decides each event when the button is released. A short press is not reported at once. The block first waits out the double-click gap window, so the first half of a double-click never shows up as a single press. Each event leaves the block as a pulse one clock cycle wide on its own output. A synchronous reset returns the block to idle and drops any sequence in progress.

Top module: `btn_press_classifier`

## Requirements
- R1: The input `btnN` is active-low (0 = pressed, 1 = released) and goes through a two-flop synchronizer before any decision. Reset holds all three event outputs at 0.
- R2: A low period longer than `T_LONG` ticks produces exactly one `evLong` pulse after the release. While the button is still held, no `evLong` pulse appears.
- R3: A low period of at least `T_SHORT` ticks and at most `T_LONG` ticks produces no event.
- R4: Two low pulses, each shorter than `T_SHORT` ticks, with a high gap between them shorter than `T_GAP` ticks, produce exactly one `evDouble` pulse and no `evSingle`.
- R5: A low pulse shorter than `T_SHORT` ticks with no second press within `T_GAP` ticks produces one `evSingle` pulse. That pulse appears only after the gap window has run out, never earlier.
- R6: Durations are counted in ticks of `CYCLES_PER_TICK` clock cycles. The counter changes value only on a tick or when it is cleared, and it saturates instead of wrapping, so a hold of any length still classifies as long.
- R7: Every event output is high for exactly one clock cycle per event, and at most one event output is high in any cycle.
- R8: If the second pulse of a candidate double-click is `T_SHORT` ticks or longer, the whole sequence is discarded with no event, and the block returns to idle.
- R9: A synchronous reset in the middle of a sequence returns the block to idle. A single press that is waiting to be reported is dropped.
- R10: Two short presses separated by a gap of `T_GAP` ticks or more are reported as two separate `evSingle` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btnN | input | 1 | Debounced button line, low while pressed (asynchronous) |
| evSingle | output | 1 | One-cycle pulse: single press classified |
| evDouble | output | 1 | One-cycle pulse: double-click classified |
| evLong | output | 1 | One-cycle pulse: long press classified |

## Verification
The bench targets these corner cases:
- Early single report: the bench checks that no single press is reported partway through the gap window. A design that reported on release would fail this.
- Double-click: the bench checks that a double-click yields only the double event. A design that also let the single escape would fail.
- Over-long second click: the bench checks that a second click that is too long wipes out the whole sequence. A design that kept the first click as a single would fail.
- Mid-length press: the bench checks that a press between the short and long limits stays silent.
- Very long hold: a hold several times the saturation value still gives a long press. A counter that wraps would give nothing or a wrong class.
- Reset mid-sequence and slow double: a reset during the gap window cancels the pending single, and a slow second press counts as a second single.

// File: rtl/btn_cls_pkg.sv
package btn_cls_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PRESS1 = 2'd1,
    ST_GAP    = 2'd2,
    ST_PRESS2 = 2'd3
  } clsState_t;

  // Strobes from control to the duration counter
  typedef struct packed {
    logic clrCnt;  // restart timing from zero
    logic runCnt;  // advance on tick
  } cntCtrl_t;

endpackage

// File: rtl/btn_cls_datapath.sv
module btn_cls_datapath
  import btn_cls_pkg::*;
#(
  parameter int CYCLES_PER_TICK = 50000,
  parameter int SAT             = 801,
  localparam int PRE_W = (CYCLES_PER_TICK > 1) ? $clog2(CYCLES_PER_TICK) : 1,
  localparam int CNT_W = $clog2(SAT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             btnN,
  input  cntCtrl_t         cntCtrl,
  output logic             pressed,
  output logic             tick,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYCLES_PER_TICK - 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(SAT);

  logic       syncA, syncB;
  logic [PRE_W-1:0] preCnt;

  // Two-flop synchronizer, idles released (high)
  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
    end else begin
      syncA <= btnN;
      syncB <= syncA;
    end
  end

  assign pressed = ~syncB;

  // Free-running prescaler
  always_ff @(posedge clk) begin
    if (rst || preCnt == PRE_LAST) preCnt <= '0;
    else                           preCnt <= preCnt + 1'b1;
  end

  assign tick = (preCnt == PRE_LAST);

  // Saturating duration counter
  always_ff @(posedge clk) begin
    if (rst || cntCtrl.clrCnt)                          cnt <= '0;
    else if (cntCtrl.runCnt && tick && cnt != CNT_SAT) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/btn_cls_control.sv
module btn_cls_control
  import btn_cls_pkg::*;
#(
  parameter int T_LONG  = 800,
  parameter int T_SHORT = 300,
  parameter int T_GAP   = 400,
  parameter int CNT_W   = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pressed,
  input  logic [CNT_W-1:0] cnt,
  output cntCtrl_t         cntCtrl,
  output logic             evSingle,
  output logic             evDouble,
  output logic             evLong
);

  localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(T_LONG);
  localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(T_SHORT);
  localparam logic [CNT_W-1:0] LIM_GAP   = CNT_W'(T_GAP);

  clsState_t state, stateNxt;
  logic singleNxt, doubleNxt, longNxt;

  always_comb begin
    stateNxt  = state;
    singleNxt = 1'b0;
    doubleNxt = 1'b0;
    longNxt   = 1'b0;
    unique case (state)
      ST_IDLE:   if (pressed) stateNxt = ST_PRESS1;
      ST_PRESS1: if (!pressed) begin
        if (cnt < LIM_SHORT) stateNxt = ST_GAP;
        else begin
          stateNxt = ST_IDLE;
          longNxt  = (cnt > LIM_LONG);
        end
      end
      ST_GAP: begin
        if (pressed && cnt < LIM_GAP) stateNxt = ST_PRESS2;
        else if (cnt >= LIM_GAP) begin
          stateNxt  = ST_IDLE;
          singleNxt = 1'b1;
        end
      end
      ST_PRESS2: if (!pressed) begin
        stateNxt  = ST_IDLE;
        doubleNxt = (cnt < LIM_SHORT);
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign cntCtrl.clrCnt = (stateNxt != state) || (state == ST_IDLE);
  assign cntCtrl.runCnt = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      evSingle <= 1'b0;
      evDouble <= 1'b0;
      evLong   <= 1'b0;
    end else begin
      state    <= stateNxt;
      evSingle <= singleNxt;
      evDouble <= doubleNxt;
      evLong   <= longNxt;
    end
  end

endmodule

// File: rtl/btn_press_classifier.sv
module btn_press_classifier
  import btn_cls_pkg::*;
#(
  parameter int CYCLES_PER_TICK = 50000,
  parameter int T_LONG          = 800,
  parameter int T_SHORT         = 300,
  parameter int T_GAP           = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic btnN,
  output logic evSingle,
  output logic evDouble,
  output logic evLong
);

  localparam int T_MAX = (T_LONG > T_GAP) ? ((T_LONG > T_SHORT) ? T_LONG : T_SHORT)
                                          : ((T_GAP > T_SHORT) ? T_GAP : T_SHORT);
  localparam int SAT   = T_MAX + 1;
  localparam int CNT_W = $clog2(SAT + 1);

  cntCtrl_t         cntCtrl;
  logic             pressed;
  logic             tick;
  logic [CNT_W-1:0] cnt;

  btn_cls_datapath #(
    .CYCLES_PER_TICK(CYCLES_PER_TICK),
    .SAT            (SAT)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .btnN   (btnN),
    .cntCtrl(cntCtrl),
    .pressed(pressed),
    .tick   (tick),
    .cnt    (cnt)
  );

  btn_cls_control #(
    .T_LONG (T_LONG),
    .T_SHORT(T_SHORT),
    .T_GAP  (T_GAP),
    .CNT_W  (CNT_W)
  ) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .pressed (pressed),
    .cnt     (cnt),
    .cntCtrl (cntCtrl),
    .evSingle(evSingle),
    .evDouble(evDouble),
    .evLong  (evLong)
  );

endmodule

// File: rtl/btn_press_classifier_chk.sv
module btn_press_classifier_chk #(
  parameter int CNT_W = 10,
  parameter int SAT   = 801
) (
  input logic             clk,
  input logic             rst,
  input logic             pressed,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic             evSingle,
  input logic             evDouble,
  input logic             evLong
);

  // R7: never two event kinds at once
  a_r7_one_event: assert property (@(posedge clk) disable iff (rst)
    $onehot0({evSingle, evDouble, evLong}));

  // R7: each pulse lasts one cycle
  a_r7_single_width: assert property (@(posedge clk) disable iff (rst)
    evSingle |=> !evSingle);
  a_r7_double_width: assert property (@(posedge clk) disable iff (rst)
    evDouble |=> !evDouble);
  a_r7_long_width: assert property (@(posedge clk) disable iff (rst)
    evLong |=> !evLong);

  // R6: counter saturates and moves upward only on a tick
  a_r6_saturate: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(SAT));
  a_r6_tick_only: assert property (@(posedge clk) disable iff (rst)
    (cnt != 0 && cnt != $past(cnt)) |-> $past(tick));

  // R2: long press is reported after release, not while held
  a_r2_on_release: assert property (@(posedge clk) disable iff (rst)
    evLong |-> !$past(pressed));

  // R4: double click is reported after the second release
  a_r4_on_release: assert property (@(posedge clk) disable iff (rst)
    evDouble |-> !$past(pressed));

endmodule

bind btn_press_classifier btn_press_classifier_chk #(
  .CNT_W(CNT_W),
  .SAT  (SAT)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .pressed (pressed),
  .tick    (tick),
  .cnt     (cnt),
  .evSingle(evSingle),
  .evDouble(evDouble),
  .evLong  (evLong)
);

// File: tb/btn_press_classifier_tb.sv
module btn_press_classifier_tb;

  localparam int CPT     = 4;
  localparam int TLONG   = 20;
  localparam int TSHORT  = 8;
  localparam int TGAP    = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btnN = 1'b1;
  logic evSingle, evDouble, evLong;

  int nChecks = 0;
  int nFails  = 0;
  int nS = 0, nD = 0, nL = 0, nViol = 0;
  logic prevS = 1'b0, prevD = 1'b0, prevL = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  btn_press_classifier #(
    .CYCLES_PER_TICK(CPT),
    .T_LONG (TLONG),
    .T_SHORT(TSHORT),
    .T_GAP  (TGAP)
  ) u_dut (
    .clk     (clk),
    .rst     (rst),
    .btnN    (btnN),
    .evSingle(evSingle),
    .evDouble(evDouble),
    .evLong  (evLong)
  );

  // Event monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      nS += int'(evSingle);
      nD += int'(evDouble);
      nL += int'(evLong);
      if ((evSingle && prevS) || (evDouble && prevD) || (evLong && prevL)) nViol++;
      if (int'(evSingle) + int'(evDouble) + int'(evLong) > 1) nViol++;
    end
    prevS = evSingle;
    prevD = evDouble;
    prevL = evLong;
  end

  task automatic check(input int actual, input int expected, input string req);
    nChecks++;
    if (actual != expected) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic waitTicks(input int n);
    repeat (n * CPT) @(negedge clk);
  endtask

  task automatic tap(input int lowTicks);
    btnN = 1'b0;
    waitTicks(lowTicks);
    btnN = 1'b1;
  endtask

  task automatic testReset();
    check(int'(evSingle) + int'(evDouble) + int'(evLong), 0, "R1 reset outputs");
  endtask

  task automatic testSingle();
    int s0 = nS, d0 = nD, l0 = nL;
    tap(4);
    waitTicks(6);
    check(nS - s0, 0, "R5 single not before gap expires");
    waitTicks(8);
    check(nS - s0, 1, "R5 single after gap");
    check((nD - d0) + (nL - l0), 0, "R5 no other event");
  endtask

  task automatic testDouble();
    int s0 = nS, d0 = nD, l0 = nL;
    tap(4);
    waitTicks(4);
    tap(4);
    waitTicks(15);
    check(nD - d0, 1, "R4 double reported");
    check(nS - s0, 0, "R4 no single on double");
    check(nL - l0, 0, "R4 no long on double");
  endtask

  task automatic testLong(input int holdTicks, input string req);
    int s0 = nS, d0 = nD, l0 = nL;
    btnN = 1'b0;
    waitTicks(holdTicks);
    check(nL - l0, 0, "R2 no long while held");
    btnN = 1'b1;
    waitTicks(3);
    check(nL - l0, 1, req);
    waitTicks(12);
    check((nS - s0) + (nD - d0), 0, req);
  endtask

  task automatic testMid();
    int s0 = nS, d0 = nD, l0 = nL;
    tap(14);
    waitTicks(15);
    check((nS - s0) + (nD - d0) + (nL - l0), 0, "R3 mid-length press silent");
  endtask

  task automatic testDiscard();
    int s0 = nS, d0 = nD, l0 = nL;
    tap(4);
    waitTicks(4);
    tap(14);
    waitTicks(15);
    check((nS - s0) + (nD - d0) + (nL - l0), 0, "R8 long second click discards");
  endtask

  task automatic testSlowPair();
    int s0 = nS, d0 = nD;
    tap(4);
    waitTicks(16);
    tap(4);
    waitTicks(15);
    check(nS - s0, 2, "R10 slow pair gives two singles");
    check(nD - d0, 0, "R10 slow pair no double");
  endtask

  task automatic testResetMid();
    int s0 = nS, d0 = nD, l0 = nL;
    tap(4);
    waitTicks(3);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    waitTicks(15);
    check((nS - s0) + (nD - d0) + (nL - l0), 0, "R9 reset cancels pending single");
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst = 1'b0;
    repeat (4) @(negedge clk);
    testReset();
    testSingle();
    testDouble();
    testLong(26, "R2 long after release");
    testMid();
    testDiscard();
    testSlowPair();
    testLong(200, "R6 saturated hold still long");
    testResetMid();
    testSingle();
    check(nViol, 0, "R7 pulse width and exclusivity");
    finishRun();
  end

endmodule